// File: doc/BRIEF.md
# Register Readiness Scoreboard with Issue-Queue Wakeup

This block keeps one ready bit per physical register and the source-operand readiness of a small set of issue-queue slots. The allocation stage writes an instruction into a chosen slot through the dispatch port. The dispatch carries up to two source tags, each with a ready hint from rename, and an optional destination tag. Dispatching clears the destination's ready bit, which claims the register for the new producer. Each source that is not yet known to be ready is looked up in the scoreboard at that moment, so a register that completed while the instruction was in flight is not missed.

When a producer finishes, the completion port presents its destination tag. The block sets that register's ready bit and broadcasts the tag to every valid slot, and each waiting source that names it becomes ready. A per-slot mask squashes slots, and a squashed slot no longer responds to wakeups. Each slot drives a ready output that the select logic outside the block reads.

The physical register count is the integer pool plus the floating-point pool. Tags at or above that count are outside tracking. A producer dispatched onto a register that still has waiting consumers raises a combinational flag.

Top module: `reg_ready_scoreboard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `reg_ready` is 0, including registers that hold architectural state, and every bit of `entry_ready` is 0.
- R2: A dispatch with `disp_dst_used` and an in-range `disp_dst_tag` makes that register's `reg_ready` bit 0 on the next cycle. This holds even when a completion names the same register in the same cycle.
- R3: A dispatched source counts as ready at once if it is unused, if its hint is 1, or if the scoreboard bit of its tag is already 1. A slot whose sources are all ready shows `entry_ready` 1 in the cycle after the dispatch.
- R4: A completion with an in-range `cmpl_tag` sets that register's bit on the next cycle, unless R2 applies. It also marks ready every waiting source in a valid slot that carries that tag. A bit of `reg_ready` only rises in the cycle after a completion.
- R5: A completion and a dispatch in the same cycle that name the same register as completion tag and source tag leave that source ready, so the wakeup is not lost.
- R6: A tag with a value of at least INT_PREGS+FP_PREGS (40 by default) is never tracked. Used as a source it counts as ready. Used as a destination or as a completion tag it leaves `reg_ready` unchanged.
- R7: `dst_conflict` is 1 in the same cycle as a dispatch with an in-range destination tag that matches a not-ready source of a valid slot that is not being squashed in that cycle. Otherwise it is 0.
- R8: Bit i of `squash_mask` invalidates slot i on the next cycle, and that slot stays not ready after later completions. A dispatch into slot i in the same cycle takes priority over the squash.
- R9: `entry_ready[i]` is 1 only when slot i is valid and every source it uses is marked ready. Slot numbers are binary encoded on `disp_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_slot | input | SLOT_W (3) | Binary slot index being written |
| disp_src0_used | input | 1 | Source 0 is present |
| disp_src0_tag | input | TAG_W (6) | Physical register of source 0 |
| disp_src0_hint | input | 1 | Rename reports source 0 ready |
| disp_src1_used | input | 1 | Source 1 is present |
| disp_src1_tag | input | TAG_W (6) | Physical register of source 1 |
| disp_src1_hint | input | 1 | Rename reports source 1 ready |
| disp_dst_used | input | 1 | Instruction writes a destination |
| disp_dst_tag | input | TAG_W (6) | Physical register of the destination |
| cmpl_valid | input | 1 | A producer completes this cycle |
| cmpl_tag | input | TAG_W (6) | Destination register of the completing producer |
| squash_mask | input | ENTRIES (8) | One bit per slot to invalidate |
| entry_ready | output | ENTRIES (8) | Slot valid with all used sources ready |
| reg_ready | output | NPREG (40) | Scoreboard ready bit per physical register |
| dst_conflict | output | 1 | Dispatched destination still has waiting consumers |

## Verification
A completion can land in the same cycle as a dispatch. When its tag equals a dispatched source, the source must come out ready (bypass). When its tag equals the dispatched destination, the claim must win. The bench drives both collisions on one clock edge. In the first case it judges the slot's ready output one cycle later. In the second case it judges the scoreboard bit one cycle later. A squash that meets a dispatch into the same slot is provoked the same way, and the new instruction must survive.

// File: rtl/reg_ready_scoreboard.sv
module reg_ready_scoreboard #(
  parameter int INT_PREGS = 24,
  parameter int FP_PREGS  = 16,
  parameter int ENTRIES   = 8,
  parameter int TAG_W     = 6,
  localparam int NPREG    = INT_PREGS + FP_PREGS,
  localparam int SLOT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [SLOT_W-1:0] disp_slot,
  input  logic              disp_src0_used,
  input  logic [TAG_W-1:0]  disp_src0_tag,
  input  logic              disp_src0_hint,
  input  logic              disp_src1_used,
  input  logic [TAG_W-1:0]  disp_src1_tag,
  input  logic              disp_src1_hint,
  input  logic              disp_dst_used,
  input  logic [TAG_W-1:0]  disp_dst_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [ENTRIES-1:0] squash_mask,
  output logic [ENTRIES-1:0] entry_ready,
  output logic [NPREG-1:0]  reg_ready,
  output logic              dst_conflict
);

  function automatic logic tracked(input logic [TAG_W-1:0] t);
    return int'(t) < NPREG;
  endfunction

  logic [NPREG-1:0]   sb_q;
  logic [ENTRIES-1:0] vld_q, r0_q, r1_q, waits;
  logic [TAG_W-1:0]   t0_q [ENTRIES];
  logic [TAG_W-1:0]   t1_q [ENTRIES];

  logic cmpl_hit, dst_hit, s0_rdy, s1_rdy;

  assign cmpl_hit = cmpl_valid && tracked(cmpl_tag);
  assign dst_hit  = disp_valid && disp_dst_used && tracked(disp_dst_tag);

  assign s0_rdy = !disp_src0_used || disp_src0_hint || !tracked(disp_src0_tag) ||
                  sb_q[disp_src0_tag] || (cmpl_hit && cmpl_tag == disp_src0_tag);
  assign s1_rdy = !disp_src1_used || disp_src1_hint || !tracked(disp_src1_tag) ||
                  sb_q[disp_src1_tag] || (cmpl_hit && cmpl_tag == disp_src1_tag);

  genvar r;
  generate
    for (r = 0; r < NPREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sb_q[r] <= 1'b0;
        else if (dst_hit && disp_dst_tag == TAG_W'(r))
          sb_q[r] <= 1'b0;
        else if (cmpl_hit && cmpl_tag == TAG_W'(r))
          sb_q[r] <= 1'b1;
      end
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < ENTRIES; i++) begin : g_ent
      logic wr;
      assign wr = disp_valid && disp_slot == SLOT_W'(i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[i] <= 1'b0;
          r0_q[i]  <= 1'b0;
          r1_q[i]  <= 1'b0;
          t0_q[i]  <= '0;
          t1_q[i]  <= '0;
        end else if (wr) begin
          vld_q[i] <= 1'b1;
          r0_q[i]  <= s0_rdy;
          r1_q[i]  <= s1_rdy;
          t0_q[i]  <= disp_src0_tag;
          t1_q[i]  <= disp_src1_tag;
        end else begin
          if (squash_mask[i]) vld_q[i] <= 1'b0;
          if (cmpl_hit && vld_q[i] && t0_q[i] == cmpl_tag) r0_q[i] <= 1'b1;
          if (cmpl_hit && vld_q[i] && t1_q[i] == cmpl_tag) r1_q[i] <= 1'b1;
        end
      end

      assign waits[i] = vld_q[i] && !squash_mask[i] &&
                        ((!r0_q[i] && t0_q[i] == disp_dst_tag) ||
                         (!r1_q[i] && t1_q[i] == disp_dst_tag));
    end
  endgenerate

  assign entry_ready  = vld_q & r0_q & r1_q;
  assign reg_ready    = sb_q;
  assign dst_conflict = dst_hit && (|waits);

endmodule

module reg_ready_scoreboard_chk #(
  parameter int INT_PREGS = 24,
  parameter int FP_PREGS  = 16,
  parameter int ENTRIES   = 8,
  parameter int TAG_W     = 6,
  localparam int NPREG    = INT_PREGS + FP_PREGS,
  localparam int SLOT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic [SLOT_W-1:0] disp_slot,
  input logic              disp_src0_used,
  input logic [TAG_W-1:0]  disp_src0_tag,
  input logic              disp_src0_hint,
  input logic              disp_src1_used,
  input logic [TAG_W-1:0]  disp_src1_tag,
  input logic              disp_src1_hint,
  input logic              disp_dst_used,
  input logic [TAG_W-1:0]  disp_dst_tag,
  input logic              cmpl_valid,
  input logic [TAG_W-1:0]  cmpl_tag,
  input logic [ENTRIES-1:0] squash_mask,
  input logic [ENTRIES-1:0] entry_ready,
  input logic [NPREG-1:0]  reg_ready,
  input logic              dst_conflict
);

  logic dst_in, cmpl_in;
  logic [ENTRIES-1:0] disp_oh, kill;

  assign dst_in  = int'(disp_dst_tag) < NPREG;
  assign cmpl_in = int'(cmpl_tag) < NPREG;
  assign disp_oh = disp_valid ? (ENTRIES'(1) << disp_slot) : '0;
  assign kill    = squash_mask & ~disp_oh;

  // R2
  dst_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_dst_used && dst_in) |=> !reg_ready[$past(disp_dst_tag)]);

  // R4
  cmpl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_in && !(disp_valid && disp_dst_used && disp_dst_tag == cmpl_tag))
    |=> reg_ready[$past(cmpl_tag)]);

  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_ready & ~$past(reg_ready)) != '0) |-> $past(cmpl_valid));

  // R6
  oor_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_dst_used && !dst_in && !cmpl_valid) |=> $stable(reg_ready));

  // R8
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill != '0) |=> ((entry_ready & $past(kill)) == '0));

  // R3
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_src0_used && !disp_src1_used) |=> entry_ready[$past(disp_slot)]);

  // R7
  conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_conflict |-> (disp_valid && disp_dst_used && dst_in));

endmodule

bind reg_ready_scoreboard reg_ready_scoreboard_chk #(
  .INT_PREGS(INT_PREGS), .FP_PREGS(FP_PREGS), .ENTRIES(ENTRIES), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/tb_reg_ready_scoreboard.sv
`timescale 1ns/1ps
module tb_reg_ready_scoreboard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid, disp_src0_used, disp_src0_hint, disp_src1_used, disp_src1_hint;
  logic disp_dst_used, cmpl_valid;
  logic [2:0] disp_slot;
  logic [5:0] disp_src0_tag, disp_src1_tag, disp_dst_tag, cmpl_tag;
  logic [7:0] squash_mask, entry_ready;
  logic [39:0] reg_ready;
  logic dst_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_ready_scoreboard dut (.*);

  typedef struct packed {
    logic dv; logic [2:0] slot;
    logic s0u; logic [5:0] s0t; logic s0h;
    logic s1u; logic [5:0] s1t; logic s1h;
    logic du; logic [5:0] dt;
    logic cv; logic [5:0] ct;
    logic [7:0] sq; logic [7:0] er; logic ec;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1,3'd0, 1'b1,6'd5,1'b0,  1'b0,6'd0,1'b0,  1'b1,6'd10, 1'b0,6'd0,  8'h00,8'h00,1'b0},
    '{1'b0,3'd0, 1'b0,6'd0,1'b0,  1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd5,  8'h00,8'h01,1'b0},
    '{1'b1,3'd1, 1'b1,6'd5,1'b0,  1'b1,6'd7,1'b1,  1'b1,6'd12, 1'b0,6'd0,  8'h00,8'h03,1'b0},
    '{1'b1,3'd2, 1'b1,6'd10,1'b0, 1'b1,6'd12,1'b0, 1'b1,6'd20, 1'b0,6'd0,  8'h00,8'h03,1'b0},
    '{1'b1,3'd3, 1'b0,6'd0,1'b0,  1'b0,6'd0,1'b0,  1'b1,6'd10, 1'b0,6'd0,  8'h00,8'h0B,1'b1},
    '{1'b0,3'd0, 1'b0,6'd0,1'b0,  1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd10, 8'h00,8'h0B,1'b0},
    '{1'b1,3'd4, 1'b1,6'd12,1'b0, 1'b1,6'd50,1'b0, 1'b0,6'd0,  1'b1,6'd12, 8'h00,8'h1F,1'b0},
    '{1'b0,3'd0, 1'b0,6'd0,1'b0,  1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b0,6'd0,  8'h03,8'h1C,1'b0},
    '{1'b1,3'd5, 1'b1,6'd20,1'b0, 1'b0,6'd0,1'b0,  1'b1,6'd63, 1'b0,6'd0,  8'h00,8'h1C,1'b0},
    '{1'b1,3'd6, 1'b1,6'd20,1'b0, 1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b0,6'd0,  8'h20,8'h1C,1'b0},
    '{1'b0,3'd0, 1'b0,6'd0,1'b0,  1'b0,6'd0,1'b0,  1'b0,6'd0,  1'b1,6'd20, 8'h00,8'h5C,1'b0}
  };

  task automatic drive(input vec_t v);
    disp_valid = v.dv; disp_slot = v.slot;
    disp_src0_used = v.s0u; disp_src0_tag = v.s0t; disp_src0_hint = v.s0h;
    disp_src1_used = v.s1u; disp_src1_tag = v.s1t; disp_src1_hint = v.s1h;
    disp_dst_used = v.du; disp_dst_tag = v.dt;
    cmpl_valid = v.cv; cmpl_tag = v.ct; squash_mask = v.sq;
  endtask

  task automatic idle();
    vec_t z;
    z = '0;
    drive(z);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic vec_t mk(input logic [2:0] slot, input logic s0u, input logic [5:0] s0t,
                              input logic s0h, input logic du, input logic [5:0] dt,
                              input logic cv, input logic [5:0] ct, input logic [7:0] sq);
    vec_t v;
    v = '0;
    v.dv = 1'b1; v.slot = slot; v.s0u = s0u; v.s0t = s0t; v.s0h = s0h;
    v.du = du; v.dt = dt; v.cv = cv; v.ct = ct; v.sq = sq;
    return v;
  endfunction

  logic [39:0] sb_exp;

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reg_ready in reset", 64'(reg_ready), 64'h0);
    check("R1 entry_ready in reset", 64'(entry_ready), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reg_ready after reset", 64'(reg_ready), 64'h0);
    check("R1 entry_ready after reset", 64'(entry_ready), 64'h0);

    // R3 R4 R5 R6 R7 R8 R9 table walk
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k]);
      #1;
      check($sformatf("R7 conflict row %0d", k), 64'(dst_conflict), 64'(TBL[k].ec));
      step();
      idle();
      check($sformatf("R9 entry_ready row %0d", k), 64'(entry_ready), 64'(TBL[k].er));
    end

    sb_exp = '0;
    sb_exp[5] = 1'b1; sb_exp[10] = 1'b1; sb_exp[12] = 1'b1; sb_exp[20] = 1'b1;
    check("R4 scoreboard after completions", 64'(reg_ready), 64'(sb_exp));

    // R2 destination claim, slot with no sources ready at once
    drive(mk(3'd7, 1'b0, 6'd0, 1'b0, 1'b1, 6'd12, 1'b0, 6'd0, 8'h00));
    step(); idle();
    sb_exp[12] = 1'b0;
    check("R2 claim clears bit", 64'(reg_ready), 64'(sb_exp));
    check("R3 no-source slot ready", 64'(entry_ready[7]), 64'h1);

    // R2 claim wins over same-cycle completion
    drive(mk(3'd7, 1'b0, 6'd0, 1'b0, 1'b1, 6'd5, 1'b1, 6'd5, 8'h00));
    step(); idle();
    sb_exp[5] = 1'b0;
    check("R2 claim beats completion", 64'(reg_ready), 64'(sb_exp));

    // R6 untracked destination and completion
    drive(mk(3'd7, 1'b0, 6'd0, 1'b0, 1'b1, 6'd45, 1'b0, 6'd0, 8'h00));
    step(); idle();
    check("R6 untracked dst", 64'(reg_ready), 64'(sb_exp));
    cmpl_valid = 1'b1; cmpl_tag = 6'd60;
    step(); idle();
    check("R6 untracked completion", 64'(reg_ready), 64'(sb_exp));

    // R8 squash meets dispatch into the same slot
    drive(mk(3'd7, 1'b1, 6'd30, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 8'h00));
    step(); idle();
    check("R3 waiting source not ready", 64'(entry_ready[7]), 64'h0);
    drive(mk(3'd7, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 8'h80));
    step(); idle();
    check("R8 dispatch beats squash", 64'(entry_ready[7]), 64'h1);

    // R3 hint makes a source ready although the scoreboard bit is 0
    drive(mk(3'd7, 1'b1, 6'd33, 1'b1, 1'b0, 6'd0, 1'b0, 6'd0, 8'h00));
    step(); idle();
    check("R3 hint ready", 64'(entry_ready[7]), 64'h1);

    // R7 waiter in a slot squashed this cycle does not count
    drive(mk(3'd0, 1'b1, 6'd40, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 8'h00));
    step(); idle();
    drive(mk(3'd1, 1'b1, 6'd15, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 8'h00));
    step(); idle();
    drive(mk(3'd2, 1'b0, 6'd0, 1'b0, 1'b1, 6'd15, 1'b0, 6'd0, 8'h02));
    #1;
    check("R7 squashed waiter ignored", 64'(dst_conflict), 64'h0);
    step(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule